// File: doc/BRIEF.md
# Running Ones-Count Divisible-by-Three Detector

The block watches a stream of 2-bit words, one per clock cycle while a valid strobe is high, and keeps track of how many 1 bits have arrived since reset. It never holds the full count. It keeps only the remainder of that count after division by three, so the state needs at most three values.

Every cycle it raises a flag when the total is divisible by three. The flag is a combinational (Mealy) output. It already includes the word presented in the current cycle. When the strobe is low, the remainder stays where it is and the flag reports whether the held total is divisible by three.

A typical use is parity-like bookkeeping on a serial symbol stream, where a downstream consumer needs a same-cycle answer without a counter that grows without bound.

Top module: `ones_mod3_detector`

## Requirements
- R1: A synchronous active-high reset sets the remainder to 0, so with the strobe low after reset the flag reads 1.
- R2: A valid word of value 2'b00 leaves the remainder unchanged.
- R3: A valid word of value 2'b01 or 2'b10 advances the remainder by one, modulo three.
- R4: A valid word of value 2'b11 advances the remainder by two, modulo three.
- R5: In a cycle with the strobe high, the flag is 1 exactly when the remainder plus the ones in the current word is divisible by three. The flag shows this in the same cycle, before the clock edge that stores the new remainder.
- R6: With the strobe low, the word is ignored: the remainder holds, and the flag is 1 exactly when the held remainder is 0.
- R7: The remainder only ever takes the values 0, 1 and 2, and wraps from 2 back to 0.
- R8: From reset, the valid words 00, 11, 10, 01, 00 produce the flag values 1, 0, 1, 0, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word strobe; the word is counted only when high |
| in_sym | input | 2 | Input word whose 1 bits are added to the total |
| hit | output | 1 | High when the total, including a valid current word, is divisible by three |

## Verification
The assertions assume two things about the inputs. The strobe and the word carry known values at every clock edge outside reset, and reset is asserted from time zero, so the remainder is never sampled before it has been set. The bench meets both conditions: it holds reset high from the start and changes the inputs only on falling edges, always to defined values. It sweeps every sequence of four steps drawn from the four words and an idle cycle, then runs a long pseudo-random stream. The expected flag comes from a plain integer count of 1 bits.

// File: rtl/ones_mod3_pkg.sv
`timescale 1ns/1ps
package ones_mod3_pkg;

    localparam int SYM_W   = 2;
    localparam int MODULUS = 3;
    localparam int RES_W   = (MODULUS > 1) ? $clog2(MODULUS) : 1;
    localparam int CNT_W   = $clog2(SYM_W + 1);

    typedef logic [RES_W-1:0] residue_t;
    typedef logic [CNT_W-1:0] ones_t;

    typedef struct packed {
        logic             valid;
        logic [SYM_W-1:0] sym;
    } beat_t;

    function automatic logic residue_is_zero(input residue_t r);
        return (r == '0);
    endfunction

endpackage

// File: rtl/sym_popcount.sv
`timescale 1ns/1ps
module sym_popcount #(
    parameter int SYM_W = ones_mod3_pkg::SYM_W,
    localparam int CNT_W = $clog2(SYM_W + 1)
) (
    input  logic [SYM_W-1:0] sym,
    output logic [CNT_W-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < SYM_W; i++) begin
            ones = ones + CNT_W'(sym[i]);
        end
    end
endmodule

// File: rtl/residue_step.sv
`timescale 1ns/1ps
module residue_step #(
    parameter int MODULUS = ones_mod3_pkg::MODULUS,
    parameter int RES_W   = ones_mod3_pkg::RES_W,
    parameter int CNT_W   = ones_mod3_pkg::CNT_W,
    localparam int SUM_W  = ((RES_W > CNT_W) ? RES_W : CNT_W) + 1
) (
    input  logic [RES_W-1:0] cur,
    input  logic [CNT_W-1:0] inc,
    output logic [RES_W-1:0] nxt
);
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(cur) + SUM_W'(inc);
        nxt = RES_W'(sum % SUM_W'(MODULUS));
    end
endmodule

// File: rtl/residue_reg.sv
`timescale 1ns/1ps
module residue_reg #(
    parameter int MODULUS = ones_mod3_pkg::MODULUS,
    parameter int RES_W   = ones_mod3_pkg::RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RES_W-1:0] d,
    output logic [RES_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        (32'(q) < MODULUS));

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/ones_mod3_detector.sv
`timescale 1ns/1ps
module ones_mod3_detector
    import ones_mod3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_sym,
    output logic             hit
);
    beat_t    beat;
    ones_t    ones;
    residue_t res_q;
    residue_t res_d;

    assign beat.valid = in_valid;
    assign beat.sym   = in_sym;

    sym_popcount #(.SYM_W(SYM_W)) u_pop (
        .sym  (beat.sym),
        .ones (ones)
    );

    residue_step #(.MODULUS(MODULUS), .RES_W(RES_W), .CNT_W(CNT_W)) u_step (
        .cur (res_q),
        .inc (ones),
        .nxt (res_d)
    );

    residue_reg #(.MODULUS(MODULUS), .RES_W(RES_W)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (beat.valid),
        .d    (res_d),
        .q    (res_q)
    );

    always_comb begin
        if (beat.valid) hit = residue_is_zero(res_d);
        else            hit = residue_is_zero(res_q);
    end

    assert_zero_word_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sym == 2'b00) |=> $stable(res_q));

    assert_single_one_steps_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_sym == 2'b01 || in_sym == 2'b10)) |=>
        (32'(res_q) == (32'($past(res_q)) + 1) % MODULUS));

    assert_double_one_steps_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sym == 2'b11) |=>
        (32'(res_q) == (32'($past(res_q)) + 2) % MODULUS));

    assert_flag_matches_stored_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hit) |=> (res_q == '0));

    assert_idle_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && hit) |=> (res_q == '0));
endmodule

// File: tb/test_ones_mod3_detector.sv
`timescale 1ns/1ps
module test_ones_mod3_detector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_sym = 2'b00;
    logic       hit;

    int checks = 0;
    int errors = 0;
    int total  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ones_mod3_detector i_ones_mod3_detector (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym), .hit(hit)
    );

    function automatic int pop2(input logic [1:0] s);
        return int'(s[0]) + int'(s[1]);
    endfunction

    function automatic string tag_for(input logic v, input logic [1:0] s);
        if (!v)            return "R6";
        if (s == 2'b00)    return "R5/R2";
        if (s == 2'b11)    return "R5/R4";
        return "R5/R3";
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: hit=%0b expected %0b (total=%0d)", req, act, exp, total);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_sym = 2'b00;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        total = 0;
    endtask

    task automatic step(input logic v, input logic [1:0] s, input string req);
        int expc;
        @(negedge clk);
        in_valid = v; in_sym = s;
        #1;
        expc = v ? total + pop2(s) : total;
        check(req, hit, (expc % 3) == 0);
        @(posedge clk);
        if (v) total = expc;
    endtask

    initial begin
        logic [1:0] seq [5];
        logic       exp_flags [5];

        do_reset();
        #1;
        check("R1", hit, 1'b1);

        seq = '{2'b00, 2'b11, 2'b10, 2'b01, 2'b00};
        exp_flags = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sym = seq[i];
            #1;
            check("R8", hit, exp_flags[i]);
            @(posedge clk);
        end

        do_reset();
        step(1'b1, 2'b01, "R7");
        step(1'b1, 2'b10, "R7");
        step(1'b1, 2'b01, "R7");
        step(1'b0, 2'b00, "R7");
        step(1'b1, 2'b11, "R7");
        step(1'b1, 2'b11, "R7");
        step(1'b1, 2'b11, "R7");

        step(1'b1, 2'b01, "R3");
        do_reset();
        #1;
        check("R1", hit, 1'b1);

        do_reset();
        step(1'b1, 2'b10, "R3");
        step(1'b0, 2'b11, "R6");
        step(1'b0, 2'b01, "R6");
        step(1'b0, 2'b10, "R6");
        step(1'b1, 2'b00, "R2");

        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                for (int c = 0; c < 5; c++)
                    for (int d = 0; d < 5; d++) begin
                        int code [4];
                        code = '{a, b, c, d};
                        do_reset();
                        for (int k = 0; k < 4; k++) begin
                            logic v;
                            logic [1:0] s;
                            v = (code[k] != 4);
                            s = v ? 2'(code[k]) : 2'(code[(k + 1) % 4]);
                            step(v, s, tag_for(v, s));
                        end
                    end

        do_reset();
        for (int n = 0; n < 3000; n++) begin
            logic v;
            logic [1:0] s;
            v = ($urandom % 4) != 0;
            s = 2'($urandom);
            step(v, s, tag_for(v, s));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule